// File: doc/BRIEF.md
# Per-Antenna Interference Frame Counter Bank

This block keeps one saturating 16-bit counter for each dual-polarisation antenna served by a signal-processing unit (eight by default, each antenna with its own ADC). An upstream detector presents a frame strobe together with a flag vector that has one bit per antenna. Every antenna whose bit is set in a strobed frame has its counter advanced by one. Detecting the interference is done elsewhere. This block only counts the frames that the detector marks.

Software-facing logic reads the bank in two ways. An indexed read returns one counter and clears it in the same cycle. A summary read returns the largest counter in the bank and clears every counter. An explicit clear strobe also empties the whole bank. A comparison tree derives the bank maximum. Its result is also kept in a register, so a running maximum is always visible one cycle after the counters change.

Top module: `rfi_frame_counter_bank`

## Requirements
- R1: After reset every counter is 0, `max_level` is 0, and `rd_valid` and `max_rd_valid` are low.
- R2: On a clock edge where `frame_valid` is high, each counter k with `rfi_flags[k]` set (bit k belongs to antenna k) increases by exactly 1. When `frame_valid` is low, `rfi_flags` has no effect.
- R3: A counter at 65535 (all ones) stays at 65535 when further flagged frames arrive. It does not wrap.
- R4: When `rd_en` is high at an edge, `rd_valid` is high in the following cycle and `rd_data` holds the value that counter `rd_idx` had before that edge. That counter becomes 0 at the edge and the other counters are unaffected.
- R5: If a counter is read, cleared or summary-read in the same cycle that a flagged frame targets it, the clear wins and the counter is 0 afterwards.
- R6: When `clear_all` is high at an edge, every counter becomes 0 at that edge.
- R7: When `max_rd_en` is high at an edge, `max_rd_valid` is high in the following cycle and `max_rd_data` holds the largest counter value from before that edge. Every counter becomes 0 at that edge.
- R8: `max_level` equals the largest counter value as it stood one clock edge earlier. It is recomputed every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One pulse per ADC frame |
| rfi_flags | input | NUM_ANT | Per-antenna interference flag for the strobed frame |
| rd_en | input | 1 | Indexed read request (clears the addressed counter) |
| rd_idx | input | IDX_W | Antenna index for the indexed read |
| clear_all | input | 1 | Clear every counter |
| max_rd_en | input | 1 | Summary read request (clears every counter) |
| rd_valid | output | 1 | Indexed read data valid |
| rd_data | output | CNT_W | Indexed read data |
| max_rd_valid | output | 1 | Summary read data valid |
| max_rd_data | output | CNT_W | Largest counter at the time of the summary read |
| max_level | output | CNT_W | Running maximum, one cycle behind the counters |

## Verification
The hardest state to reach from the ports is saturation. A counter reaches 65535 only after that many flagged frames with no read or clear in between. The bench therefore streams about 65,540 back-to-back frames with only antenna 0 flagged, then checks the running maximum and the indexed read value at the ceiling. Clear priority is reached by raising a read, a bank clear or a summary read in the same cycle as an all-ones flagged frame. Every cycle of every sequence also compares `max_level` against the maximum of a model taken one edge earlier.

// File: rtl/rfi_cnt_pkg.sv
package rfi_cnt_pkg;

    localparam int DEF_NUM_ANT = 8;
    localparam int DEF_CNT_W   = 16;

    // Action applied to one counter in a cycle
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INC  = 2'd1,
        ACT_CLR  = 2'd2
    } cnt_act_e;

    // Clearing beats counting when both are requested
    function automatic cnt_act_e pick_action(input logic clr, input logic inc);
        if (clr)
            return ACT_CLR;
        else if (inc)
            return ACT_INC;
        else
            return ACT_HOLD;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rfi_sat_counter.sv
module rfi_sat_counter
    import rfi_cnt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_act_e         act,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case (act)
                ACT_CLR: count <= '0;
                ACT_INC: begin
                    if (count != CNT_MAX)
                        count <= count + CNT_ONE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rfi_max_tree.sv
module rfi_max_tree #(
    parameter int NUM_IN = 8,
    parameter int W      = 16
) (
    input  logic [W-1:0] vals [NUM_IN],
    output logic [W-1:0] max_val
);
    localparam int LEVELS = (NUM_IN > 1) ? $clog2(NUM_IN) : 0;
    localparam int PAD    = 1 << LEVELS;

    for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
        localparam int N = PAD >> lv;
        logic [W-1:0] node [N];
        if (lv == 0) begin : g_leaf
            for (genvar k = 0; k < N; k++) begin : g_k
                if (k < NUM_IN) begin : g_real
                    assign node[k] = vals[k];
                end else begin : g_pad
                    assign node[k] = '0;
                end
            end
        end else begin : g_cmp
            for (genvar k = 0; k < N; k++) begin : g_k
                assign node[k] = (g_lvl[lv-1].node[2*k] > g_lvl[lv-1].node[2*k+1])
                               ? g_lvl[lv-1].node[2*k] : g_lvl[lv-1].node[2*k+1];
            end
        end
    end

    assign max_val = g_lvl[LEVELS].node[0];
endmodule

// File: rtl/rfi_read_port.sv
module rfi_read_port #(
    parameter int NUM_ANT = 8,
    parameter int CNT_W   = 16,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] counts [NUM_ANT],
    input  logic [CNT_W-1:0] tree_max,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             max_rd_en,
    output logic             rd_valid,
    output logic [CNT_W-1:0] rd_data,
    output logic             max_rd_valid,
    output logic [CNT_W-1:0] max_rd_data
);
    logic [CNT_W-1:0] sel_val;

    if (NUM_ANT == (1 << IDX_W)) begin : g_full
        assign sel_val = counts[rd_idx];
    end else begin : g_part
        always_comb begin
            sel_val = '0;
            for (int k = 0; k < NUM_ANT; k++) begin
                if (rd_idx == IDX_W'(k))
                    sel_val = counts[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid     <= 1'b0;
            rd_data      <= '0;
            max_rd_valid <= 1'b0;
            max_rd_data  <= '0;
        end else begin
            rd_valid     <= rd_en;
            max_rd_valid <= max_rd_en;
            if (rd_en)
                rd_data <= sel_val;
            if (max_rd_en)
                max_rd_data <= tree_max;
        end
    end
endmodule

// File: rtl/rfi_frame_counter_bank.sv
module rfi_frame_counter_bank
    import rfi_cnt_pkg::*;
#(
    parameter int NUM_ANT = DEF_NUM_ANT,
    parameter int CNT_W   = DEF_CNT_W,
    localparam int IDX_W  = idx_width(NUM_ANT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_valid,
    input  logic [NUM_ANT-1:0] rfi_flags,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic               clear_all,
    input  logic               max_rd_en,
    output logic               rd_valid,
    output logic [CNT_W-1:0]   rd_data,
    output logic               max_rd_valid,
    output logic [CNT_W-1:0]   max_rd_data,
    output logic [CNT_W-1:0]   max_level
);
    logic [CNT_W-1:0] counts [NUM_ANT];
    logic [CNT_W-1:0] tree_max;
    logic             bank_clr;

    assign bank_clr = clear_all | max_rd_en;

    for (genvar k = 0; k < NUM_ANT; k++) begin : g_ant
        logic     hit;
        cnt_act_e act;
        assign hit = rd_en && (rd_idx == IDX_W'(k));
        assign act = pick_action(bank_clr | hit, frame_valid & rfi_flags[k]);

        rfi_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .act   (act),
            .count (counts[k])
        );
    end

    rfi_max_tree #(.NUM_IN(NUM_ANT), .W(CNT_W)) u_tree (
        .vals    (counts),
        .max_val (tree_max)
    );

    always_ff @(posedge clk) begin
        if (rst)
            max_level <= '0;
        else
            max_level <= tree_max;
    end

    rfi_read_port #(.NUM_ANT(NUM_ANT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_rd (
        .clk          (clk),
        .rst          (rst),
        .counts       (counts),
        .tree_max     (tree_max),
        .rd_en        (rd_en),
        .rd_idx       (rd_idx),
        .max_rd_en    (max_rd_en),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .max_rd_valid (max_rd_valid),
        .max_rd_data  (max_rd_data)
    );
endmodule

// File: rtl/rfi_bank_checker.sv
module rfi_bank_checker #(
    parameter int NUM_ANT = 8,
    parameter int CNT_W   = 16,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               frame_valid,
    input logic [NUM_ANT-1:0] rfi_flags,
    input logic               rd_en,
    input logic [IDX_W-1:0]   rd_idx,
    input logic               clear_all,
    input logic               max_rd_en,
    input logic               rd_valid,
    input logic [CNT_W-1:0]   rd_data,
    input logic               max_rd_valid,
    input logic [CNT_W-1:0]   max_rd_data,
    input logic [CNT_W-1:0]   max_level
);
    AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R4
    AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid); // R4
    AST_MAX_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        max_rd_en |=> max_rd_valid); // R7
    AST_MAX_RD_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        max_rd_en |=> ##1 (max_level == '0)); // R7
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clear_all |=> ##1 (max_level == '0)); // R6
    AST_MAX_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (max_level > $past(max_level)) |->
        ({1'b0, max_level} == {1'b0, $past(max_level)} + 1'b1)); // R2
endmodule

bind rfi_frame_counter_bank rfi_bank_checker #(
    .NUM_ANT(NUM_ANT), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/rfi_frame_counter_bank_tb.sv
module rfi_frame_counter_bank_tb;
    localparam int NA    = 8;
    localparam int CW    = 16;
    localparam int IW    = 3;
    localparam int CMAX  = 65535;

    logic          clk = 1'b0;
    logic          rst;
    logic          frame_valid, rd_en, clear_all, max_rd_en;
    logic [NA-1:0] rfi_flags;
    logic [IW-1:0] rd_idx;
    logic          rd_valid, max_rd_valid;
    logic [CW-1:0] rd_data, max_rd_data, max_level;

    int model [NA];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rfi_frame_counter_bank #(.NUM_ANT(NA), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .rfi_flags(rfi_flags),
        .rd_en(rd_en), .rd_idx(rd_idx), .clear_all(clear_all), .max_rd_en(max_rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .max_rd_valid(max_rd_valid),
        .max_rd_data(max_rd_data), .max_level(max_level)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_max();
        int m = 0;
        for (int k = 0; k < NA; k++) if (model[k] > m) m = model[k];
        return m;
    endfunction

    // One cycle: drive at negedge, step, check at next negedge
    task automatic cyc(input bit fv, input logic [NA-1:0] fl, input bit rd,
                       input int idx, input bit clr, input bit mrd);
        int exp_rd, exp_mx;
        frame_valid = fv; rfi_flags = fl; rd_en = rd; rd_idx = IW'(idx);
        clear_all = clr; max_rd_en = mrd;
        exp_rd = model[idx];
        exp_mx = model_max();
        for (int k = 0; k < NA; k++) begin
            if (clr || mrd || (rd && idx == k)) model[k] = 0;
            else if (fv && fl[k] && model[k] < CMAX) model[k]++;
        end
        @(posedge clk);
        @(negedge clk);
        frame_valid = 0; rfi_flags = '0; rd_en = 0; clear_all = 0; max_rd_en = 0;
        // R8: running maximum lags the counters by one edge
        chk(int'(max_level) == exp_mx, "R8", int'(max_level), exp_mx);
        chk(rd_valid == rd, "R4 valid", int'(rd_valid), int'(rd));
        chk(max_rd_valid == mrd, "R7 valid", int'(max_rd_valid), int'(mrd));
        if (rd)  chk(int'(rd_data) == exp_rd, "R4 data", int'(rd_data), exp_rd);
        if (mrd) chk(int'(max_rd_data) == exp_mx, "R7 data", int'(max_rd_data), exp_mx);
    endtask

    task automatic read_all(input string tag);
        for (int k = 0; k < NA; k++) begin
            int e = model[k];
            cyc(0, '0, 1, k, 0, 0);
            chk(int'(rd_data) == e, tag, int'(rd_data), e);
        end
    endtask

    initial begin
        for (int k = 0; k < NA; k++) model[k] = 0;
        rst = 1; frame_valid = 0; rfi_flags = '0; rd_en = 0; rd_idx = '0;
        clear_all = 0; max_rd_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(max_level == '0, "R1 max_level", int'(max_level), 0);
        chk(!rd_valid && !max_rd_valid, "R1 valids", int'(rd_valid), 0);
        read_all("R1 counter");

        // R2: flag pattern sweep, with unstrobed flags interleaved
        for (int n = 0; n < 300; n++) begin
            cyc(1, NA'((n * 37 + 5) ^ (n >> 2)), 0, 0, 0, 0);
            if (n % 3 == 0) cyc(0, '1, 0, 0, 0, 0);
        end
        cyc(0, '0, 0, 0, 0, 0);
        read_all("R2 count");

        // R2: every single-bit and all-ones pattern
        for (int b = 0; b < NA; b++)
            for (int r = 0; r <= b; r++) cyc(1, NA'(1) << b, 0, 0, 0, 0);
        cyc(1, '1, 0, 0, 0, 0);
        read_all("R2 onehot");

        // R5: read collides with increment on each antenna
        for (int k = 0; k < NA; k++) cyc(1, '1, 0, 0, 0, 0);
        for (int k = 0; k < NA; k++) cyc(1, '1, 1, k, 0, 0);
        read_all("R5 read-vs-inc");

        // R6 + R5: clear_all collides with increment
        for (int k = 0; k < 5; k++) cyc(1, NA'(8'hA5), 0, 0, 0, 0);
        cyc(1, '1, 0, 0, 1, 0);
        read_all("R6 clear");

        // R7 + R5: summary read collides with increment
        for (int k = 0; k < 20; k++) cyc(1, NA'(k), 0, 0, 0, 0);
        cyc(1, '1, 0, 0, 0, 1);
        read_all("R7 cleared");

        // R3: saturation of antenna 0
        for (int n = 0; n < CMAX + 5; n++) cyc(1, NA'(1), 0, 0, 0, 0);
        cyc(0, '0, 0, 0, 0, 0);
        chk(int'(max_level) == CMAX, "R3 max_level", int'(max_level), CMAX);
        cyc(0, '0, 0, 0, 0, 1);
        chk(int'(max_rd_data) == CMAX, "R3 summary", int'(max_rd_data), CMAX);
        for (int n = 0; n < CMAX + 2; n++) cyc(1, NA'(1), 0, 0, 0, 0);
        cyc(0, '0, 1, 0, 0, 0);
        chk(int'(rd_data) == CMAX, "R3 read", int'(rd_data), CMAX);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule